// File: doc/BRIEF.md
# Integer Ordering, Carry, Zero-Count and Byte-Lane Match Unit

This block sits next to an integer ALU and evaluates one of five operations on two 32-bit operands per request. It can form an ordering value for signed or unsigned operands, produce the carry out of an add with carry-in, count the leading zeros of the first operand, or find the first equal byte lane between the two operands. The operations themselves are combinational. One register stage at the output holds the result and raises a valid strobe.

The ordering value is the difference b − a with its top bit overridden when the operands' sign bits differ. The top bit therefore always says whether b lies below a, and the low bits keep the difference. The byte-lane match scans from the most significant byte downward and returns a 1-based lane number, or zero if no lane matches.

Top module: `operand_relation_unit`

## Requirements
- R1: With op_sel = 0 (signed ordering), result is b − a (computed as b + ~a + 1). When opa[31] and opb[31] differ, bit 31 of result is replaced by opb[31], so bit 31 is set exactly when opb < opa as signed numbers.
- R2: With op_sel = 1 (unsigned ordering), result is the same difference. When the sign bits differ, bit 31 is replaced by opa[31], so bit 31 is set exactly when opb < opa as unsigned numbers.
- R3: With op_sel = 2, result bit 0 is the carry out of opa + opb + carry_in, and bits 31:1 are zero.
- R4: With op_sel = 3, result is the number of zero bits of opa above its highest set bit, and is 32 when opa is zero.
- R5: With op_sel = 4, the byte lanes 31:24, 23:16, 15:8 and 7:0 of opa and opb are compared in that order. result is 1, 2, 3 or 4 for the first lane that is equal, or 0 when no lane is equal.
- R6: op_sel codes 5, 6 and 7 give a result of zero.
- R7: out_valid is high in the cycle after in_valid is high, and low in the cycle after in_valid is low. result carries the answer in that same cycle.
- R8: While in_valid is low, result holds its previous value whatever the other inputs do.
- R9: While rst is high, out_valid and result are cleared to zero at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op_sel | input | 3 | Operation code (0..4 used) |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| carry_in | input | 1 | Carry input for the carry operation |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| result | output | 32 | Registered result |

## Verification
The only state is the output register and its valid flag, so every fault shows up in the cycle after the request. A bad capture enable shows as a result that drifts while in_valid is low, or as a valid strobe that is missing or stuck. A wrong lane priority, override bit or zero-count boundary shows as a wrong value on the very next out_valid. For that reason the vectors are chosen at the sign-crossing, all-ones, all-zero and multiple-match points, where such faults change the visible value.

// File: rtl/orel_pkg.sv
package orel_pkg;

    localparam int unsigned DW      = 32;
    localparam int unsigned LANE_W  = 8;
    localparam int unsigned OPW     = 3;

    typedef enum logic [OPW-1:0] {
        OP_ORD_S = 3'd0,
        OP_ORD_U = 3'd1,
        OP_CARRY = 3'd2,
        OP_LZC   = 3'd3,
        OP_LANE  = 3'd4
    } op_e;

    typedef struct packed {
        logic          vld;
        logic [DW-1:0] val;
    } res_t;

    // Replace the top bit of a difference when operand signs disagree.
    function automatic logic [DW-1:0] ord_fix(input logic [DW-1:0] diff,
                                              input logic a_top,
                                              input logic b_top,
                                              input logic uns);
        logic [DW-1:0] r;
        r = diff;
        if (a_top != b_top) r[DW-1] = uns ? a_top : b_top;
        return r;
    endfunction

endpackage

// File: rtl/orel_order.sv
module orel_order #(
    parameter int unsigned W = orel_pkg::DW
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         uns,
    output logic [W-1:0] ord
);
    logic [W-1:0] diff;

    always_comb begin
        diff = b + ~a + W'(1);
        ord  = diff;
        if (a[W-1] != b[W-1]) ord[W-1] = uns ? a[W-1] : b[W-1];
    end
endmodule

// File: rtl/orel_carry.sv
module orel_carry #(
    parameter int unsigned W = orel_pkg::DW
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic         cout
);
    logic [W:0] wide;

    always_comb begin
        wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        cout = wide[W];
    end
endmodule

// File: rtl/orel_lzc.sv
module orel_lzc #(
    parameter int unsigned W  = orel_pkg::DW,
    localparam int unsigned CW = $clog2(W) + 1
) (
    input  logic [W-1:0]  x,
    output logic [CW-1:0] cnt
);
    always_comb begin
        cnt = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (x[i]) cnt = CW'(W - 1 - i);
        end
    end
endmodule

// File: rtl/orel_lane.sv
module orel_lane #(
    parameter int unsigned W  = orel_pkg::DW,
    parameter int unsigned LW = orel_pkg::LANE_W,
    localparam int unsigned NL = W / LW,
    localparam int unsigned IW = $clog2(NL + 1)
) (
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    output logic [IW-1:0] idx
);
    logic [NL-1:0] eq;

    // Lane k = 0 is the most significant byte.
    for (genvar k = 0; k < NL; k++) begin : g_lane
        assign eq[k] = (a[W-1-k*LW -: LW] == b[W-1-k*LW -: LW]);
    end

    always_comb begin
        idx = '0;
        for (int k = NL - 1; k >= 0; k--) begin
            if (eq[k]) idx = IW'(k + 1);
        end
    end
endmodule

// File: rtl/operand_relation_unit.sv
module operand_relation_unit
    import orel_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [2:0]    op_sel,
    input  logic [31:0]   opa,
    input  logic [31:0]   opb,
    input  logic          carry_in,
    output logic          out_valid,
    output logic [31:0]   result
);
    localparam int unsigned W  = DW;
    localparam int unsigned CW = $clog2(W) + 1;
    localparam int unsigned NL = W / LANE_W;
    localparam int unsigned IW = $clog2(NL + 1);

    logic [W-1:0]  ord_val;
    logic          cy;
    logic [CW-1:0] zc;
    logic [IW-1:0] lane_idx;
    logic [W-1:0]  comb_val;
    res_t          q;
    op_e           op;

    assign op = op_e'(op_sel);

    orel_order #(.W(W)) u_order (
        .a(opa), .b(opb), .uns(op == OP_ORD_U), .ord(ord_val)
    );

    orel_carry #(.W(W)) u_carry (
        .a(opa), .b(opb), .cin(carry_in), .cout(cy)
    );

    orel_lzc #(.W(W)) u_lzc (
        .x(opa), .cnt(zc)
    );

    orel_lane #(.W(W), .LW(LANE_W)) u_lane (
        .a(opa), .b(opb), .idx(lane_idx)
    );

    always_comb begin
        unique case (op)
            OP_ORD_S, OP_ORD_U: comb_val = ord_val;
            OP_CARRY:           comb_val = W'(cy);
            OP_LZC:             comb_val = W'(zc);
            OP_LANE:            comb_val = W'(lane_idx);
            default:            comb_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q.vld <= in_valid;
            if (in_valid) q.val <= comb_val;
        end
    end

    assign out_valid = q.vld;
    assign result    = q.val;

    // R7
    valid_launch_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R7
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));
    // R6
    unused_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel > 3'd4) |=> result == '0);
    // R4
    lzc_range_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 3'd3) |=> result <= 32'(W));
    // R3
    carry_width_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 3'd2) |=> result[W-1:1] == '0);
    // R5
    lane_range_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 3'd4) |=> result <= 32'(NL));

endmodule

// File: tb/test_operand_relation_unit.sv
`timescale 1ns/1ps
module test_operand_relation_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [2:0]  op_sel;
    logic [31:0] opa, opb;
    logic        carry_in;
    logic        out_valid;
    logic [31:0] result;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    operand_relation_unit i_operand_relation_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
        .opa(opa), .opb(opb), .carry_in(carry_in),
        .out_valid(out_valid), .result(result)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] m_order(input logic [31:0] a, input logic [31:0] b, input bit uns);
        logic [31:0] d;
        d = b - a;
        if (a[31] != b[31]) d[31] = uns ? a[31] : b[31];
        return d;
    endfunction

    function automatic logic [31:0] m_carry(input logic [31:0] a, input logic [31:0] b, input logic c);
        logic [32:0] s;
        s = {1'b0, a} + {1'b0, b} + {32'd0, c};
        return {31'd0, s[32]};
    endfunction

    function automatic logic [31:0] m_lzc(input logic [31:0] x);
        for (int i = 31; i >= 0; i--) if (x[i]) return 32'(31 - i);
        return 32'd32;
    endfunction

    function automatic logic [31:0] m_lane(input logic [31:0] a, input logic [31:0] b);
        for (int k = 0; k < 4; k++)
            if (a[31-8*k -: 8] == b[31-8*k -: 8]) return 32'(k + 1);
        return 32'd0;
    endfunction

    // One request, then check strobe and value in the following cycle.
    task automatic apply(input string req, input logic [2:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic c, input logic [31:0] exp);
        @(negedge clk);
        in_valid = 1'b1; op_sel = op; opa = a; opb = b; carry_in = c;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " R7 valid"}, {31'd0, out_valid}, 32'd1);
        check(req, result, exp);
    endtask

    task automatic t_reset;
        @(negedge clk);
        in_valid = 1'b1; op_sel = 3'd0; opa = 32'h1; opb = 32'h5;
        rst = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        // R9
        check("R9 out_valid", {31'd0, out_valid}, 32'd0);
        check("R9 result", result, 32'd0);
        rst = 1'b0;
    endtask

    task automatic t_signed;
        apply("R1 same sign", 3'd0, 32'd5, 32'd3, 1'b0, m_order(32'd5, 32'd3, 0));
        apply("R1 a neg b pos", 3'd0, 32'h8000_0000, 32'd1, 1'b0, 32'h0000_0001);
        apply("R1 a pos b neg", 3'd0, 32'd1, 32'hFFFF_FFFF, 1'b0, 32'hFFFF_FFFE);
        apply("R1 equal", 3'd0, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b0, 32'd0);
    endtask

    task automatic t_unsigned;
        apply("R2 a top set", 3'd1, 32'h8000_0000, 32'd1, 1'b0, 32'h8000_0001);
        apply("R2 b top set", 3'd1, 32'd1, 32'hFFFF_FFFF, 1'b0, 32'h7FFF_FFFE);
        apply("R2 same sign", 3'd1, 32'd3, 32'd9, 1'b0, m_order(32'd3, 32'd9, 1));
    endtask

    task automatic t_carry;
        apply("R3 ones plus cin", 3'd2, 32'd0, 32'hFFFF_FFFF, 1'b1, 32'd1);
        apply("R3 wrap", 3'd2, 32'hFFFF_FFFF, 32'd1, 1'b0, 32'd1);
        apply("R3 no carry", 3'd2, 32'h7FFF_FFFF, 32'h8000_0000, 1'b0, 32'd0);
        apply("R3 edge cin", 3'd2, 32'h7FFF_FFFF, 32'h8000_0000, 1'b1, 32'd1);
        apply("R3 model", 3'd2, 32'h9ABC_0000, 32'h7000_1234, 1'b0,
              m_carry(32'h9ABC_0000, 32'h7000_1234, 1'b0));
    endtask

    task automatic t_lzc;
        apply("R4 zero", 3'd3, 32'd0, 32'd0, 1'b0, 32'd32);
        apply("R4 one", 3'd3, 32'd1, 32'd0, 1'b0, 32'd31);
        apply("R4 top", 3'd3, 32'h8000_0000, 32'd0, 1'b0, 32'd0);
        apply("R4 mid", 3'd3, 32'h0001_0F00, 32'd0, 1'b0, m_lzc(32'h0001_0F00));
    endtask

    task automatic t_lane;
        apply("R5 first lane", 3'd4, 32'h1234_5678, 32'h1200_0078, 1'b0, 32'd1);
        apply("R5 second lane", 3'd4, 32'hAABB_CCDD, 32'h00BB_00DD, 1'b0, 32'd2);
        apply("R5 last lane", 3'd4, 32'hAABB_CCDD, 32'h0000_00DD, 1'b0, 32'd4);
        apply("R5 none", 3'd4, 32'h0102_0304, 32'h1020_3040, 1'b0, 32'd0);
        apply("R5 model", 3'd4, 32'h5566_7788, 32'h0066_7700, 1'b0,
              m_lane(32'h5566_7788, 32'h0066_7700));
    endtask

    task automatic t_unused;
        for (int c = 5; c < 8; c++)
            apply("R6 unused code", 3'(c), 32'hFFFF_FFFF, 32'h1234_5678, 1'b1, 32'd0);
    endtask

    task automatic t_hold;
        logic [31:0] kept;
        apply("R8 setup", 3'd3, 32'h0000_00F0, 32'd0, 1'b0, 32'd24);
        kept = result;
        @(negedge clk);
        in_valid = 1'b0; op_sel = 3'd0; opa = 32'h1; opb = 32'h7777_0000;
        @(negedge clk);
        check("R8 held", result, kept);
        check("R7 idle valid", {31'd0, out_valid}, 32'd0);
        opa = 32'h0; op_sel = 3'd4;
        @(negedge clk);
        check("R8 held again", result, kept);
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; op_sel = '0; opa = '0; opb = '0; carry_in = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_signed();
        t_unsigned();
        t_carry();
        t_lzc();
        t_lane();
        t_unused();
        t_hold();
        t_reset();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule